// File: doc/BRIEF.md
# Dual Match-Compare Timer

The block holds two independent counters that software reaches through a simple register bus with one-cycle access. Each counter has its own reload value, two compare values and a direction. It counts once per clock, or once per pulse of a shared external tick-enable input. A down-counting timer that has reached zero reloads on its next step. An up-counting timer that is at its all-ones value reloads in the same way. Either case is a wrap event. Every step that lands the counter on a compare value is a match event.

The six events (two matches and one wrap per timer) set sticky bits in one shared status register. Software clears a bit by writing it as 0. One shared mask register selects which status bits reach the two interrupt lines, one line per timer. A typical use runs timer 0 downward as a periodic tick source and timer 1 upward as a free-running timestamp.

Top module: `dual_match_timer`

## Requirements
- R1: Word addresses: timer t (t = 0, 1) has its counter at 4t+0, reload at 4t+1, compare A at 4t+2 and compare B at 4t+3. Control is at 8, status at 9 and mask at 10. All of them can be written. A read with `rd_en` returns the selected register on `rdata` one cycle later, and a read changes no state.
- R2: Control bits [4t+3:4t] are, from high to low: dir_up, src_ext, ovf_en, run. A timer steps on a cycle only when run is 1 and either src_ext is 0 or `ext_tick` is 1. With run at 0, or with src_ext at 1 and no tick, the counter holds.
- R3: With dir_up at 0, a step decrements the counter. A step taken while the counter is 0 loads the reload value instead and raises a wrap event.
- R4: With dir_up at 1, a step increments the counter. A step taken while the counter is all ones loads the reload value instead and raises a wrap event.
- R5: When a step gives the counter a new value equal to compare A, status bit 3t is set. When it equals compare B, status bit 3t+1 is set. This happens whatever ovf_en holds.
- R6: A wrap event sets status bit 3t+2 only when that timer's ovf_en is 1.
- R7: A bus write to a counter takes priority over a step in the same cycle. The written value is loaded and no match or wrap event is raised.
- R8: A status write clears each bit written as 0 and keeps each bit written as 1. A bit set by an event in the same cycle as a clear stays set.
- R9: Mask bits [5:0] line up with the status bits, and a mask bit at 0 lets its source through. `irq[t]` is high exactly while some status bit of timer t is set with its mask bit at 0. It follows status and mask with no extra delay.
- R10: Reset clears the counters, reload and compare values, control, status and `rdata`, sets the mask to 0x3F and drives both interrupt lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after `rd_en` |
| ext_tick | input | 1 | External tick enable for timers set to src_ext |
| irq | output | 2 | Per-timer interrupt, bit t for timer t |

## Verification
Assertions check on every cycle the local laws of the design. A counter write lands as written. An idle timer holds its value. A down step subtracts one, and an up wrap loads the reload value. An event bit survives a clear in the same cycle. A wrap bit can only rise with ovf_en set. The interrupt lines always equal status ANDed with the inverted mask, and `rdata` changes only after a read. The bench's scenarios show the end-to-end sequences: both directions reaching and crossing their wrap points, match hits on reloaded values, gating by the external tick, free-running count lengths, the priority of a counter write, and the interaction between clearing and masking.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int NUM_TMR     = 2;
  localparam int EVT_PER_TMR = 3;
  localparam int NUM_EVT     = NUM_TMR * EVT_PER_TMR;
  localparam int CTRL_PER    = 4;
  localparam int CTRL_W      = NUM_TMR * CTRL_PER;
  localparam int REG_PER_TMR = 4;

  // per-timer register offsets inside a timer's window
  localparam int OFS_CNT  = 0;
  localparam int OFS_RLD  = 1;
  localparam int OFS_CMPA = 2;
  localparam int OFS_CMPB = 3;
  // shared registers
  localparam int ADR_CTRL = NUM_TMR * REG_PER_TMR;
  localparam int ADR_STAT = ADR_CTRL + 1;
  localparam int ADR_MASK = ADR_CTRL + 2;

  typedef struct packed {
    logic dir_up;
    logic src_ext;
    logic ovf_en;
    logic run;
  } tmr_ctrl_t;

  typedef struct packed {
    logic wrap;
    logic mb;
    logic ma;
  } tmr_evt_t;

  typedef tmr_ctrl_t [NUM_TMR-1:0] ctrl_vec_t;
  typedef tmr_evt_t  [NUM_TMR-1:0] evt_vec_t;
endpackage

// File: rtl/dmt_channel.sv
module dmt_channel
  import dmt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              src_ext,
  input  logic              dir_up,
  input  logic              ext_tick,
  input  logic              wr_cnt,
  input  logic              wr_rld,
  input  logic              wr_cmpa,
  input  logic              wr_cmpb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] rld_o,
  output logic [DATA_W-1:0] cmpa_o,
  output logic [DATA_W-1:0] cmpb_o,
  output tmr_evt_t          evt_o
);
  logic [DATA_W-1:0] cnt_q, rld_q, cmpa_q, cmpb_q;
  logic [DATA_W-1:0] nxt;
  logic adv, step, at_edge;

  // a step happens when running and the selected clock source fires
  assign adv     = run & (src_ext ? ext_tick : 1'b1);
  assign step    = adv & ~wr_cnt;
  assign at_edge = dir_up ? (cnt_q == {DATA_W{1'b1}}) : (cnt_q == '0);

  always_comb begin
    if (at_edge)     nxt = rld_q;
    else if (dir_up) nxt = cnt_q + DATA_W'(1);
    else             nxt = cnt_q - DATA_W'(1);
  end

  assign evt_o.ma   = step & (nxt == cmpa_q);
  assign evt_o.mb   = step & (nxt == cmpb_q);
  assign evt_o.wrap = step & at_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
    end else begin
      if (wr_cnt)    cnt_q <= wdata;
      else if (step) cnt_q <= nxt;
      if (wr_rld)  rld_q  <= wdata;
      if (wr_cmpa) cmpa_q <= wdata;
      if (wr_cmpb) cmpb_q <= wdata;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign cmpa_o = cmpa_q;
  assign cmpb_o = cmpb_q;

  // R7: bus write lands verbatim regardless of stepping
  assert_cnt_write_R7: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt_q == $past(wdata)));

  // R2: no step and no write means the counter holds
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!adv && !wr_cnt) |=> $stable(cnt_q));

  // R3: a down step away from zero subtracts one
  assert_down_step_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !dir_up && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - DATA_W'(1)));

  // R4: an up step at all ones loads the reload value
  assert_up_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (step && dir_up && (cnt_q == {DATA_W{1'b1}})) |=> (cnt_q == $past(rld_q)));
endmodule

// File: rtl/dmt_regbank.sv
module dmt_regbank
  import dmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_ctrl,
  input  logic                 wr_stat,
  input  logic                 wr_mask,
  input  logic [CTRL_W-1:0]    wdata,
  input  evt_vec_t             evt,
  output ctrl_vec_t            ctrl_o,
  output logic [NUM_EVT-1:0]   stat_o,
  output logic [NUM_EVT-1:0]   mask_o,
  output logic [NUM_TMR-1:0]   irq_o
);
  ctrl_vec_t            ctrl_q;
  logic [NUM_EVT-1:0]   stat_q, stat_d, mask_q, mask_d, hw_set;
  logic [NUM_TMR-1:0]   irq_q, irq_d;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_src
    assign hw_set[EVT_PER_TMR*t+0] = evt[t].ma;
    assign hw_set[EVT_PER_TMR*t+1] = evt[t].mb;
    assign hw_set[EVT_PER_TMR*t+2] = evt[t].wrap & ctrl_q[t].ovf_en;
    assign irq_d[t] = |(stat_d[EVT_PER_TMR*t +: EVT_PER_TMR] &
                        ~mask_d[EVT_PER_TMR*t +: EVT_PER_TMR]);
  end

  // clear-by-zero write, then hardware sets win
  assign stat_d = (wr_stat ? (stat_q & wdata[NUM_EVT-1:0]) : stat_q) | hw_set;
  assign mask_d = wr_mask ? wdata[NUM_EVT-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      stat_q <= '0;
      mask_q <= '1;
      irq_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_vec_t'(wdata);
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_q  <= irq_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chk_bit
    // R8: an event in a clearing cycle survives
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
      hw_set[i] |=> stat_q[i]);
    // R8: a zero write without a concurrent event clears
    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_stat && !wdata[i] && !hw_set[i]) |=> !stat_q[i]);
  end

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk_tmr
    // R6: the wrap bit rises only with ovf_en set
    assert_wrap_gate_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_q[EVT_PER_TMR*t+2]) |-> $past(ctrl_q[t].ovf_en));
    // R9: interrupt line tracks unmasked status
    assert_irq_track_R9: assert property (@(posedge clk) disable iff (rst)
      irq_q[t] == |(stat_q[EVT_PER_TMR*t +: EVT_PER_TMR] &
                    ~mask_q[EVT_PER_TMR*t +: EVT_PER_TMR]));
  end
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_tick,
  output logic [NUM_TMR-1:0] irq
);
  logic [DATA_W-1:0] cnt_a  [NUM_TMR];
  logic [DATA_W-1:0] rld_a  [NUM_TMR];
  logic [DATA_W-1:0] cmpa_a [NUM_TMR];
  logic [DATA_W-1:0] cmpb_a [NUM_TMR];
  ctrl_vec_t          ctrl;
  evt_vec_t           evt;
  logic [NUM_EVT-1:0] stat, mask;
  logic [DATA_W-1:0]  rd_mux, rdata_q;
  logic               sel_ctrl, sel_stat, sel_mask;

  assign sel_ctrl = (addr == ADDR_W'(ADR_CTRL));
  assign sel_stat = (addr == ADDR_W'(ADR_STAT));
  assign sel_mask = (addr == ADDR_W'(ADR_MASK));

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam int BASE = REG_PER_TMR * t;
    dmt_channel #(.DATA_W(DATA_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .run     (ctrl[t].run),
      .src_ext (ctrl[t].src_ext),
      .dir_up  (ctrl[t].dir_up),
      .ext_tick(ext_tick),
      .wr_cnt  (wr_en && addr == ADDR_W'(BASE + OFS_CNT)),
      .wr_rld  (wr_en && addr == ADDR_W'(BASE + OFS_RLD)),
      .wr_cmpa (wr_en && addr == ADDR_W'(BASE + OFS_CMPA)),
      .wr_cmpb (wr_en && addr == ADDR_W'(BASE + OFS_CMPB)),
      .wdata   (wdata),
      .cnt_o   (cnt_a[t]),
      .rld_o   (rld_a[t]),
      .cmpa_o  (cmpa_a[t]),
      .cmpb_o  (cmpb_a[t]),
      .evt_o   (evt[t])
    );
  end

  dmt_regbank u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_ctrl(wr_en && sel_ctrl),
    .wr_stat(wr_en && sel_stat),
    .wr_mask(wr_en && sel_mask),
    .wdata  (wdata[CTRL_W-1:0]),
    .evt    (evt),
    .ctrl_o (ctrl),
    .stat_o (stat),
    .mask_o (mask),
    .irq_o  (irq)
  );

  always_comb begin
    rd_mux = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (addr == ADDR_W'(REG_PER_TMR*t + OFS_CNT))  rd_mux = cnt_a[t];
      if (addr == ADDR_W'(REG_PER_TMR*t + OFS_RLD))  rd_mux = rld_a[t];
      if (addr == ADDR_W'(REG_PER_TMR*t + OFS_CMPA)) rd_mux = cmpa_a[t];
      if (addr == ADDR_W'(REG_PER_TMR*t + OFS_CMPB)) rd_mux = cmpb_a[t];
    end
    if (sel_ctrl) rd_mux = DATA_W'(ctrl);
    if (sel_stat) rd_mux = DATA_W'(stat);
    if (sel_mask) rd_mux = DATA_W'(mask);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;

  // R1: read data moves only in response to a read
  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));
endmodule

// File: tb/dual_match_timer_test.sv
module dual_match_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IQ = 2'd3;
  localparam int NV = 34;
  // {op, requirement number, address, data or expected value}
  localparam logic [41:0] VEC [NV] = '{
    {OP_WR, 4'd1,  4'd1,  32'd3},          // R1 reload0 = 3
    {OP_WR, 4'd1,  4'd0,  32'd2},          // R1 counter0 = 2
    {OP_WR, 4'd1,  4'd2,  32'd1},          // R1 compare A0 = 1
    {OP_WR, 4'd1,  4'd3,  32'd3},          // R1 compare B0 = 3
    {OP_WR, 4'd9,  4'd10, 32'd0},          // R9 unmask all
    {OP_WR, 4'd2,  4'd8,  32'h7},          // R2 t0 run, ovf_en, ext, down
    {OP_RD, 4'd2,  4'd0,  32'd2},          // R2 no tick yet: holds
    {OP_TK, 4'd3,  4'd0,  32'd0},          // R3 2 -> 1
    {OP_RD, 4'd3,  4'd0,  32'd1},
    {OP_RD, 4'd5,  4'd9,  32'h1},          // R5 match A0
    {OP_IQ, 4'd9,  4'd0,  32'h1},          // R9 irq0 only
    {OP_TK, 4'd3,  4'd0,  32'd0},          // R3 1 -> 0
    {OP_TK, 4'd3,  4'd0,  32'd0},          // R3 0 -> reload 3, wrap
    {OP_RD, 4'd3,  4'd0,  32'd3},
    {OP_RD, 4'd6,  4'd9,  32'h7},          // R6 wrap bit with ovf_en, R5 match B0 on reload
    {OP_WR, 4'd8,  4'd9,  32'h6},          // R8 clear bit 0 only
    {OP_RD, 4'd8,  4'd9,  32'h6},
    {OP_WR, 4'd8,  4'd9,  32'h0},          // R8 clear all
    {OP_IQ, 4'd9,  4'd0,  32'h0},          // R9 nothing pending
    {OP_WR, 4'd1,  4'd4,  32'hFFFF_FFFE},  // R1 counter1
    {OP_WR, 4'd1,  4'd5,  32'h10},         // R1 reload1
    {OP_WR, 4'd1,  4'd6,  32'hFFFF_FFFF},  // R1 compare A1
    {OP_WR, 4'd1,  4'd7,  32'h10},         // R1 compare B1
    {OP_WR, 4'd2,  4'd8,  32'hD0},         // R2 t1 run, ext, up, ovf off; t0 off
    {OP_TK, 4'd4,  4'd0,  32'd0},          // R4 -> all ones, match A1
    {OP_TK, 4'd4,  4'd0,  32'd0},          // R4 wrap -> reload 0x10, match B1
    {OP_RD, 4'd4,  4'd4,  32'h10},
    {OP_RD, 4'd6,  4'd9,  32'h18},         // R6 no wrap bit with ovf_en off
    {OP_IQ, 4'd9,  4'd0,  32'h2},          // R9 irq1 only
    {OP_WR, 4'd9,  4'd10, 32'h18},         // R9 mask bits 3 and 4
    {OP_IQ, 4'd9,  4'd0,  32'h0},
    {OP_RD, 4'd1,  4'd8,  32'hD0},         // R1 control readback
    {OP_RD, 4'd1,  4'd10, 32'h18},         // R1 mask readback
    {OP_RD, 4'd2,  4'd0,  32'd3}           // R2 stopped timer0 held
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, ext_tick = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_match_timer #(.DATA_W(32), .ADDR_W(4)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_tick(ext_tick), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic pulse_tick();
    ext_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    ext_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check("R10 irq", {30'd0, irq}, 32'h0);
    bus_read(4'd0,  32'h0,  "R10 counter0");
    bus_read(4'd9,  32'h0,  "R10 status");
    bus_read(4'd10, 32'h3F, "R10 mask");
    bus_read(4'd8,  32'h0,  "R10 control");

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][37:34], i);
      case (VEC[i][41:40])
        OP_WR: bus_write(VEC[i][35:32] == 4'd0 && 1'b0 ? 4'd0 : VEC[i][35:32], VEC[i][31:0]);
        OP_RD: bus_read(VEC[i][35:32], VEC[i][31:0], tag);
        OP_TK: pulse_tick();
        default: check(tag, {30'd0, irq}, VEC[i][31:0]);
      endcase
    end

    // R2 free-running on the internal clock: 4 idle edges plus the stop edge
    bus_write(4'd0, 32'd10);
    bus_write(4'd8, 32'h3);
    repeat (4) @(posedge clk);
    @(negedge clk);
    bus_write(4'd8, 32'h0);
    bus_read(4'd0, 32'd5, "R2 internal clock five steps");
    // R2 external source with no tick holds
    bus_write(4'd8, 32'h7);
    repeat (3) @(negedge clk);
    bus_read(4'd0, 32'd5, "R2 external source without tick");

    // R7 counter write beats a step that would have matched
    bus_write(4'd9, 32'h0);
    bus_write(4'd2, 32'd4);
    ext_tick = 1'b1;
    bus_write(4'd0, 32'h55);
    ext_tick = 1'b0;
    bus_read(4'd0, 32'h55, "R7 written value kept");
    bus_read(4'd9, 32'h0,  "R7 no event on write cycle");

    // R8 event and clear in the same cycle: event wins
    bus_write(4'd0, 32'd5);
    ext_tick = 1'b1;
    bus_write(4'd9, 32'h0);
    ext_tick = 1'b0;
    bus_read(4'd9, 32'h1, "R8 set beats clear");
    check("R9 irq0 from surviving bit", {30'd0, irq}, 32'h1);

    // R4 up wrap with ovf_en: wrap bit and match B on reload value
    bus_write(4'd4, 32'hFFFF_FFFF);
    bus_write(4'd8, 32'hF0);
    pulse_tick();
    bus_read(4'd4, 32'h10, "R4 up wrap reload");
    bus_read(4'd9, 32'h31, "R6 wrap bit timer1 with ovf_en");
    check("R9 both lines", {30'd0, irq}, 32'h3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule